// File: doc/BRIEF.md
# Gap-Delimited Serial Command Receiver

This block takes an asynchronous serial line carrying command messages at 115200 baud and collects the incoming bytes into one of two equal byte buffers (2048 bytes each by default). Messages are not framed by any length field: a message ends when the line stays idle for a programmable number of bit times (1152 by default, roughly 10 ms). When that idle gap is seen, the buffer being filled is closed and offered to the consumer together with its byte count and a status word, and reception moves on to the other buffer.

The consumer sees a single descriptor stream with valid/ready flow control. While a descriptor is valid, the closed buffer can be read through a byte-addressed read port with one cycle of latency. Accepting the descriptor (valid and ready high in the same cycle) releases that buffer for reuse. Back-pressure rules: the descriptor count and status stay stable for as long as valid is high and ready is low; the consumer may hold ready low indefinitely; while it does, the receiver keeps appending new messages to the buffer it is filling and flags an overrun for that buffer rather than discarding data.

The line is sampled at 16 times the bit rate using a clock-enable derived from the system clock. Each character is one start bit, eight data bits sent least significant first, one parity bit and one stop bit.

Top module: `cmdrx_gap_rx`

## Requirements
- R1: After reset, desc_valid is low and no descriptor is offered until a message has been received and closed by an idle gap.
- R2: A character is a low start bit, eight data bits least significant first, one parity bit and one high stop bit; received bytes are stored at addresses 0, 1, 2, ... of the filling buffer in arrival order, and rd_data returns the byte at rd_addr of the offered buffer one clock after rd_addr is applied.
- R3: A falling edge on serial_in starts a character only if the line is still low at the sample taken near the middle of the start bit; a low pulse shorter than half a bit time stores nothing.
- R4: When serial_in has been idle for GAP_BITS bit times after a character, the filling buffer is closed and offered with desc_count equal to the number of bytes stored; characters separated by shorter idle times land in the same buffer, and an idle gap with no bytes received produces no descriptor.
- R5: After a buffer is closed and handed over, later bytes are written into the other buffer starting at address 0; the two buffers alternate.
- R6: Parity is even when ODD_PARITY is 0 and odd when it is 1; a character whose parity does not match is still stored and sets desc_status bit 1 for its buffer.
- R7: A character whose stop bit is sampled low is still stored and sets desc_status bit 0 for its buffer.
- R8: Bytes arriving after the filling buffer holds BUF_BYTES bytes are dropped; desc_count then equals BUF_BYTES and desc_status bit 2 is set.
- R9: If the previously offered buffer has not been accepted when a gap closes the filling buffer, no swap takes place: the offered descriptor is unchanged, reception continues in the same buffer after the bytes already there, and desc_status bit 3 is set when that buffer is finally offered.
- R10: While desc_valid is high and desc_ready is low, desc_valid, desc_count and desc_status hold their values; a cycle with both high accepts the descriptor, and desc_valid is low in the next cycle unless a new buffer is closed in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| serial_in | input | 1 | Asynchronous serial line, idle high |
| rd_addr | input | $clog2(BUF_BYTES) | Byte address into the offered buffer |
| rd_data | output | 8 | Byte read from the offered buffer, one cycle after rd_addr |
| desc_valid | output | 1 | A closed buffer is offered |
| desc_ready | input | 1 | Consumer accepts and releases the offered buffer |
| desc_count | output | $clog2(BUF_BYTES+1) | Number of bytes in the offered buffer |
| desc_status | output | 4 | Bit 0 framing error, bit 1 parity error, bit 2 overflow, bit 3 overrun |

## Verification
The receiver is driven with back-to-back characters separated by less than a gap, which tells one message apart from several, and with a short low glitch ahead of a real character, which separates a true start bit from noise. Characters with a flipped parity bit and with a low stop bit show that each error lands in its own status bit while the byte is still kept, and an odd-parity instance on the same line shows the parity sense is selectable. A message longer than the buffer separates dropping from wrapping, and holding the descriptor unaccepted across a second message shows that data is appended rather than swapped or lost, with the overrun flag reported on the later buffer.

// File: rtl/cmdrx_pkg.sv
package cmdrx_pkg;

  // Status word of one buffer; packed order gives bit 3..0 as listed
  typedef struct packed {
    logic overrun;     // bit 3
    logic overflow;    // bit 2
    logic parity_err;  // bit 1
    logic framing_err; // bit 0
  } rx_flags_t;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_t;

  localparam int OVERSAMPLE = 16;

endpackage

// File: rtl/cmdrx_tick_gen.sv
// Clock enable at 16x the bit rate
module cmdrx_tick_gen #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      if (cnt == LAST) begin
        cnt  <= '0;
        tick <= 1'b1;
      end else begin
        cnt  <= cnt + 1'b1;
        tick <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cmdrx_uart_rx.sv
// Oversampling character receiver: start, 8 data LSB first, parity, stop
module cmdrx_uart_rx
  import cmdrx_pkg::*;
#(
  parameter bit ODD_PARITY = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       serial_in,
  output logic       busy,
  output logic       byte_valid,
  output logic [7:0] byte_data,
  output logic       byte_perr,
  output logic       byte_ferr
);
  localparam logic [3:0] MID_START = 4'(OVERSAMPLE / 2 - 1);
  localparam logic [3:0] FULL_BIT  = 4'(OVERSAMPLE - 1);

  logic [1:0] sync;
  logic       rxs;
  rx_state_t  state;
  logic [3:0] phase;
  logic [2:0] bitn;
  logic [7:0] shreg;
  logic       parbit;

  assign rxs  = sync[1];
  assign busy = (state != RX_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], serial_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= RX_IDLE;
      phase      <= '0;
      bitn       <= '0;
      shreg      <= '0;
      parbit     <= 1'b0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
      byte_perr  <= 1'b0;
      byte_ferr  <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      if (tick) begin
        unique case (state)
          RX_IDLE: begin
            phase <= '0;
            if (!rxs) state <= RX_START;
          end
          RX_START: begin
            if (phase == MID_START) begin
              phase <= '0;
              bitn  <= '0;
              state <= rxs ? RX_IDLE : RX_DATA;
            end else begin
              phase <= phase + 1'b1;
            end
          end
          RX_DATA: begin
            if (phase == FULL_BIT) begin
              phase <= '0;
              shreg <= {rxs, shreg[7:1]};
              if (bitn == 3'd7) state <= RX_PAR;
              else              bitn  <= bitn + 1'b1;
            end else begin
              phase <= phase + 1'b1;
            end
          end
          RX_PAR: begin
            if (phase == FULL_BIT) begin
              phase  <= '0;
              parbit <= rxs;
              state  <= RX_STOP;
            end else begin
              phase <= phase + 1'b1;
            end
          end
          RX_STOP: begin
            if (phase == FULL_BIT) begin
              phase      <= '0;
              byte_valid <= 1'b1;
              byte_data  <= shreg;
              byte_perr  <= ((^{shreg, parbit}) != ODD_PARITY);
              byte_ferr  <= !rxs;
              state      <= RX_IDLE;
            end else begin
              phase <= phase + 1'b1;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/cmdrx_gap_timer.sv
// Counts idle bit times; emits one pulse per idle stretch at the threshold
module cmdrx_gap_timer
  import cmdrx_pkg::*;
#(
  parameter int GAP_BITS = 1152
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic busy,
  output logic gap
);
  localparam int BW = $clog2(GAP_BITS + 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(GAP_BITS - 1);
  localparam logic [3:0]    LAST_SUB = 4'(OVERSAMPLE - 1);

  logic [3:0]    sub;
  logic [BW-1:0] bits;
  logic          fired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub   <= '0;
      bits  <= '0;
      fired <= 1'b0;
      gap   <= 1'b0;
    end else begin
      gap <= 1'b0;
      if (busy) begin
        sub   <= '0;
        bits  <= '0;
        fired <= 1'b0;
      end else if (tick && !fired) begin
        if (sub == LAST_SUB) begin
          sub <= '0;
          if (bits == LAST_BIT) begin
            bits  <= '0;
            fired <= 1'b1;
            gap   <= 1'b1;
          end else begin
            bits <= bits + 1'b1;
          end
        end else begin
          sub <= sub + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cmdrx_bank.sv
// One byte buffer: one write port, one registered read port
module cmdrx_bank #(
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cmdrx_gap_rx.sv
module cmdrx_gap_rx
  import cmdrx_pkg::*;
#(
  parameter int CLKS_PER_TICK = 10,
  parameter int BUF_BYTES     = 2048,
  parameter int GAP_BITS      = 1152,
  parameter bit ODD_PARITY    = 1'b0,
  localparam int AW = $clog2(BUF_BYTES),
  localparam int CW = $clog2(BUF_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          serial_in,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          desc_valid,
  input  logic          desc_ready,
  output logic [CW-1:0] desc_count,
  output logic [3:0]    desc_status
);
  localparam int NBANK = 2;
  localparam logic [CW-1:0] CAP = CW'(BUF_BYTES);

  logic       tick;
  logic       busy;
  logic       byte_valid;
  logic [7:0] byte_data;
  logic       byte_perr;
  logic       byte_ferr;
  logic       gap;

  cmdrx_tick_gen #(.DIV(CLKS_PER_TICK)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  cmdrx_uart_rx #(.ODD_PARITY(ODD_PARITY)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .serial_in(serial_in),
    .busy(busy), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_perr(byte_perr), .byte_ferr(byte_ferr)
  );

  cmdrx_gap_timer #(.GAP_BITS(GAP_BITS)) u_gap (
    .clk(clk), .rst_n(rst_n), .tick(tick), .busy(busy), .gap(gap)
  );

  // Buffer control
  logic          act;       // bank being filled
  logic [CW-1:0] fill;
  rx_flags_t     flags;
  logic          pend;
  logic [CW-1:0] d_count;
  rx_flags_t     d_flags;
  logic          room;
  logic          accept;
  logic          other_free;
  logic          close;

  assign room       = (fill < CAP);
  assign accept     = pend && desc_ready;
  assign other_free = !pend || desc_ready;
  assign close      = gap && (fill != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act     <= 1'b0;
      fill    <= '0;
      flags   <= '0;
      pend    <= 1'b0;
      d_count <= '0;
      d_flags <= '0;
    end else begin
      if (byte_valid) begin
        if (room) fill <= fill + 1'b1;
        else      flags.overflow <= 1'b1;
        if (byte_perr) flags.parity_err  <= 1'b1;
        if (byte_ferr) flags.framing_err <= 1'b1;
      end
      if (accept) pend <= 1'b0;
      if (close) begin
        if (other_free) begin
          pend    <= 1'b1;
          d_count <= fill;
          d_flags <= flags;
          act     <= ~act;
          fill    <= '0;
          flags   <= '0;
        end else begin
          flags.overrun <= 1'b1;
        end
      end
    end
  end

  assign desc_valid  = pend;
  assign desc_count  = d_count;
  assign desc_status = d_flags;

  // Storage
  logic [7:0] bank_rdata [NBANK];
  logic       rd_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_sel <= 1'b1;
    else        rd_sel <= ~act;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic we;
    assign we = byte_valid && room && (act == 1'(b));
    cmdrx_bank #(.DEPTH(BUF_BYTES), .AW(AW)) u_bank (
      .clk(clk), .we(we), .waddr(fill[AW-1:0]), .wdata(byte_data),
      .raddr(rd_addr), .rdata(bank_rdata[b])
    );
  end

  assign rd_data = bank_rdata[rd_sel];

endmodule

// File: rtl/cmdrx_gap_rx_checker.sv
module cmdrx_gap_rx_checker #(
  parameter int BUF_BYTES = 2048,
  parameter int CW        = $clog2(BUF_BYTES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          serial_in,
  input logic          desc_valid,
  input logic          desc_ready,
  input logic [CW-1:0] desc_count,
  input logic [3:0]    desc_status
);
  // R10: offer is held stable under back-pressure
  assert_hold_offer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && !desc_ready) |=> (desc_valid && $stable(desc_count) && $stable(desc_status)));

  // R8: count never exceeds capacity
  assert_count_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> (desc_count <= CW'(BUF_BYTES)));

  // R8: overflow only reported on a full buffer
  assert_overflow_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && desc_status[2]) |-> (desc_count == CW'(BUF_BYTES)));

  // R4: no empty buffer is offered
  assert_no_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> (desc_count != '0));

  // R4: a new offer follows an idle line
  assert_offer_after_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(desc_valid) |-> $past(serial_in));
endmodule

bind cmdrx_gap_rx cmdrx_gap_rx_checker #(.BUF_BYTES(BUF_BYTES), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .serial_in(serial_in), .desc_valid(desc_valid),
  .desc_ready(desc_ready), .desc_count(desc_count), .desc_status(desc_status)
);

// File: tb/cmdrx_gap_rx_test.sv
`timescale 1ns/1ps
module cmdrx_gap_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int BUF  = 4;
  localparam int GAP  = 24;
  localparam int AW   = $clog2(BUF);
  localparam int CW   = $clog2(BUF + 1);
  localparam int BITC = 16;  // clocks per bit with one tick per clock

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          serial_in = 1'b1;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;
  logic          desc_valid;
  logic          desc_ready = 1'b0;
  logic [CW-1:0] desc_count;
  logic [3:0]    desc_status;

  logic [7:0]    o_rd_data;
  logic          o_valid;
  logic          o_ready = 1'b0;
  logic [CW-1:0] o_count;
  logic [3:0]    o_status;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmdrx_gap_rx #(.CLKS_PER_TICK(1), .BUF_BYTES(BUF), .GAP_BITS(GAP), .ODD_PARITY(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .serial_in(serial_in), .rd_addr(rd_addr), .rd_data(rd_data),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_count(desc_count),
    .desc_status(desc_status)
  );

  cmdrx_gap_rx #(.CLKS_PER_TICK(1), .BUF_BYTES(BUF), .GAP_BITS(GAP), .ODD_PARITY(1'b1)) uut_odd (
    .clk(clk), .rst_n(rst_n), .serial_in(serial_in), .rd_addr(rd_addr), .rd_data(o_rd_data),
    .desc_valid(o_valid), .desc_ready(o_ready), .desc_count(o_count),
    .desc_status(o_status)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    @(negedge clk) serial_in = 1'b0;
    repeat (BITC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      serial_in = d[i];
      repeat (BITC) @(negedge clk);
    end
    serial_in = (^d) ^ bad_par;
    repeat (BITC) @(negedge clk);
    if (bad_stop) begin
      serial_in = 1'b0;
      repeat (12) @(negedge clk);
      serial_in = 1'b1;
      repeat (4) @(negedge clk);
    end else begin
      serial_in = 1'b1;
      repeat (BITC) @(negedge clk);
    end
    repeat (BITC) @(negedge clk);
  endtask

  task automatic idle_bits(input int n);
    serial_in = 1'b1;
    repeat (n * BITC) @(negedge clk);
  endtask

  task automatic wait_desc(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (desc_valid) begin ok = 1'b1; break; end
    end
  endtask

  task automatic read_byte(input int a, output logic [7:0] v);
    @(negedge clk) rd_addr = AW'(a);
    @(negedge clk) v = rd_data;
  endtask

  task automatic accept_desc(input string req);
    @(negedge clk) desc_ready = 1'b1;
    @(negedge clk) desc_ready = 1'b0;
    check(req, desc_valid, 0);
  endtask

  task automatic t_reset;
    check("R1 valid after reset", desc_valid, 0);
    idle_bits(GAP + 20);
    check("R4 idle gap without bytes", desc_valid, 0);
  endtask

  task automatic t_basic;
    bit ok;
    logic [7:0] v;
    send_byte(8'hA5, 0, 0);
    send_byte(8'h3C, 0, 0);
    send_byte(8'h01, 0, 0);
    wait_desc(ok);
    check("R4 descriptor offered", ok, 1);
    check("R4 one message count", desc_count, 3);
    check("R6 even parity clean status", desc_status, 0);
    read_byte(0, v); check("R2 byte0", v, 8'hA5);
    read_byte(1, v); check("R2 byte1", v, 8'h3C);
    read_byte(2, v); check("R2 byte2", v, 8'h01);
    repeat (50) @(negedge clk);
    check("R10 held valid", desc_valid, 1);
    check("R10 held count", desc_count, 3);
    check("R6 odd instance flags parity", o_status[1], 1);
    o_ready = 1'b1;
    accept_desc("R10 accept clears valid");
  endtask

  task automatic t_glitch;
    bit ok;
    logic [7:0] v;
    @(negedge clk) serial_in = 1'b0;
    repeat (4) @(negedge clk);
    serial_in = 1'b1;
    repeat (BITC * 2) @(negedge clk);
    send_byte(8'h5A, 0, 0);
    wait_desc(ok);
    check("R3 glitch ignored count", desc_count, 1);
    read_byte(0, v); check("R5 other bank byte0", v, 8'h5A);
    accept_desc("R10 accept glitch msg");
  endtask

  task automatic t_errors;
    bit ok;
    logic [7:0] v;
    send_byte(8'h11, 1, 0);
    send_byte(8'h22, 0, 1);
    send_byte(8'h33, 0, 0);
    wait_desc(ok);
    check("R7 errored bytes kept count", desc_count, 3);
    check("R6 parity bit1 R7 framing bit0", desc_status, 4'b0011);
    read_byte(1, v); check("R7 framing byte stored", v, 8'h22);
    accept_desc("R10 accept error msg");
  endtask

  task automatic t_overflow;
    bit ok;
    logic [7:0] v;
    for (int i = 0; i < 6; i++) send_byte(8'h40 + 8'(i), 0, 0);
    wait_desc(ok);
    check("R8 count capped", desc_count, BUF);
    check("R8 overflow bit2", desc_status, 4'b0100);
    read_byte(3, v); check("R8 last kept byte", v, 8'h43);
    read_byte(0, v); check("R8 first byte not overwritten", v, 8'h40);
    accept_desc("R10 accept overflow msg");
  endtask

  task automatic t_overrun;
    bit ok;
    logic [7:0] v;
    send_byte(8'h71, 0, 0);
    wait_desc(ok);
    check("R9 first msg count", desc_count, 1);
    send_byte(8'h72, 0, 0);
    send_byte(8'h73, 0, 0);
    idle_bits(GAP + 10);
    check("R9 offer unchanged count", desc_count, 1);
    check("R9 offer unchanged status", desc_status, 0);
    read_byte(0, v); check("R9 offered data intact", v, 8'h71);
    accept_desc("R10 accept before overrun report");
    send_byte(8'h74, 0, 0);
    wait_desc(ok);
    check("R9 appended count", desc_count, 3);
    check("R9 overrun bit3", desc_status, 4'b1000);
    read_byte(0, v); check("R9 appended byte0", v, 8'h72);
    read_byte(2, v); check("R9 appended byte2", v, 8'h74);
    accept_desc("R10 accept overrun msg");
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_glitch();
    t_errors();
    t_overflow();
    t_overrun();
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule